// File: doc/BRIEF.md
# Two-Bit Four-Operation Arithmetic Unit

This block is combinational. It reads two small unsigned operands from one packed input bus and returns four results at the same moment: the sum, the difference, the product and the integer quotient. Each result sits on its own output that is `RESW` bits wide. With the default widths every result fits in a single display digit, so any result can go straight into a one-digit seven-segment decoder.

The difference is given as sign plus magnitude. A separate flag goes high when the first operand is smaller than the second, and the difference output then carries the size of the gap. Division by zero is reported on its own flag, and the quotient output is held at zero in that case so that its value is always defined.

The operand width, the result width and the way the product is built are parameters. The product can come from a shift-and-add array or from the native multiply operator.

Top module: `quad_op_alu`

## Requirements
- R1: The first operand `A` is bus bits [2*OPW-1:OPW]. The second operand `B` is bus bits [OPW-1:0]. Both are unsigned, so with OPW=2 each ranges from 0 to 3.
- R2: `sum_o` equals A+B, zero-extended to RESW bits. With defaults its maximum is 6.
- R3: When A<B, `neg_o` is 1 and `diff_o` equals B-A (for example, 1 minus 3 gives neg_o=1 and diff_o=2). When A>B, `neg_o` is 0 and `diff_o` equals A-B.
- R4: When A equals B, `neg_o` is 0 and `diff_o` is 0.
- R5: `prod_o` equals A*B, zero-extended. With defaults its maximum is 9 and it does not overflow. This holds for both product styles.
- R6: When B is not 0, `quot_o` is A divided by B, truncated toward zero (for example, 3/2 gives 1).
- R7: `dz_o` is 1 exactly when B is 0.
- R8: When B is 0, `quot_o` is all zeros, whatever the value of A.
- R9: All six outputs follow a change on the operand bus with no clock edge. They are valid in the same cycle in which the operands are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 2*OPW | Packed operands: first operand in the upper half, second operand in the lower half |
| sum_o | output | RESW | Sum A+B |
| diff_o | output | RESW | Magnitude of A-B |
| prod_o | output | RESW | Product A*B |
| quot_o | output | RESW | Truncated quotient A/B, zero when B is 0 |
| neg_o | output | 1 | High when A<B |
| dz_o | output | 1 | High when B is 0 |

## Verification
The hardest cases are the ones where the divider's restoring stages all take a zero divisor, which would produce an all-ones raw quotient if the forcing to zero failed. Equal operands are also a weak spot, because a borrow-based sign could flip there. With only sixteen operand pairs, the bench reaches every one of these cases by a full directed sweep. It then adds seeded random pairs, and every output is compared with reference arithmetic computed in bench functions.

// File: rtl/qa_pkg.sv
package qa_pkg;
   typedef enum logic {
      MUL_NATIVE   = 1'b0,
      MUL_SHIFTADD = 1'b1
   } mul_style_e;

   localparam int unsigned QA_OPW_DEF  = 2;
   localparam int unsigned QA_RESW_DEF = 4;
endpackage

// File: rtl/qa_addsub.sv
module qa_addsub #(
   parameter int unsigned OPW  = 2,
   parameter int unsigned RESW = 4
) (
   input  logic [OPW-1:0]  a_i,
   input  logic [OPW-1:0]  b_i,
   output logic [RESW-1:0] sum_o,
   output logic [RESW-1:0] mag_o,
   output logic            neg_o
);
   localparam int unsigned SUMW = OPW + 1;

   logic [SUMW-1:0] sum_w;
   logic [OPW-1:0]  fwd_w;
   logic [OPW-1:0]  rev_w;
   logic            lt_w;

   assign sum_w = SUMW'(a_i) + SUMW'(b_i);
   assign lt_w  = (a_i < b_i);
   assign fwd_w = a_i - b_i;
   assign rev_w = b_i - a_i;

   assign sum_o = RESW'(sum_w);
   assign mag_o = lt_w ? RESW'(rev_w) : RESW'(fwd_w);
   assign neg_o = lt_w;
endmodule

// File: rtl/qa_mul.sv
module qa_mul #(
   parameter int unsigned       OPW   = 2,
   parameter int unsigned       RESW  = 4,
   parameter qa_pkg::mul_style_e STYLE = qa_pkg::MUL_SHIFTADD
) (
   input  logic [OPW-1:0]  a_i,
   input  logic [OPW-1:0]  b_i,
   output logic [RESW-1:0] prod_o
);
   localparam int unsigned PW = 2 * OPW;

   logic [PW-1:0] prod_w;

   generate
      if (STYLE == qa_pkg::MUL_SHIFTADD) begin : g_shiftadd
         logic [PW-1:0] acc [OPW+1];
         assign acc[0] = '0;
         for (genvar i = 0; i < OPW; i++) begin : g_row
            logic [PW-1:0] pp;
            assign pp       = b_i[i] ? (PW'(a_i) << i) : '0;
            assign acc[i+1] = acc[i] + pp;
         end
         assign prod_w = acc[OPW];
      end else begin : g_native
         assign prod_w = PW'(a_i) * PW'(b_i);
      end
   endgenerate

   assign prod_o = RESW'(prod_w);
endmodule

// File: rtl/qa_div.sv
module qa_div #(
   parameter int unsigned OPW  = 2,
   parameter int unsigned RESW = 4
) (
   input  logic [OPW-1:0]  a_i,
   input  logic [OPW-1:0]  b_i,
   output logic [RESW-1:0] quot_o,
   output logic            zero_o
);
   logic [OPW-1:0] rem [OPW];
   logic [OPW-1:0] q_w;
   logic           bz_w;

   assign rem[0] = '0;
   assign bz_w   = (b_i == '0);

   generate
      for (genvar k = 0; k < OPW; k++) begin : g_stage
         localparam int unsigned IDX = OPW - 1 - k;
         logic [OPW:0]   shifted;
         logic [OPW-1:0] reduced;
         logic           take;
         assign shifted  = {rem[k], a_i[IDX]};
         assign take     = (shifted >= {1'b0, b_i});
         assign reduced  = shifted[OPW-1:0] - b_i;
         assign q_w[IDX] = take;
         if (k < OPW - 1) begin : g_next
            assign rem[k+1] = take ? reduced : shifted[OPW-1:0];
         end else begin : g_last
            logic [OPW-1:0] rem_final;
            assign rem_final = take ? reduced : shifted[OPW-1:0];
            logic unused_rem;
            assign unused_rem = ^rem_final;
         end
      end
   endgenerate

   assign quot_o = bz_w ? '0 : RESW'(q_w);
   assign zero_o = bz_w;
endmodule

// File: rtl/quad_op_alu.sv
module quad_op_alu #(
   parameter int unsigned        OPW       = qa_pkg::QA_OPW_DEF,
   parameter int unsigned        RESW      = qa_pkg::QA_RESW_DEF,
   parameter qa_pkg::mul_style_e MUL_STYLE = qa_pkg::MUL_SHIFTADD
) (
   input  logic [2*OPW-1:0] opnd_i,
   output logic [RESW-1:0]  sum_o,
   output logic [RESW-1:0]  diff_o,
   output logic [RESW-1:0]  prod_o,
   output logic [RESW-1:0]  quot_o,
   output logic             neg_o,
   output logic             dz_o
);
   localparam int unsigned BUSW = 2 * OPW;

   generate
      if (OPW < 1) begin : g_bad_opw
         $error("quad_op_alu: OPW must be at least 1");
      end
      if (RESW < BUSW) begin : g_bad_resw
         $error("quad_op_alu: RESW must hold a full product");
      end
   endgenerate

   logic [OPW-1:0] a_w;
   logic [OPW-1:0] b_w;

   assign a_w = opnd_i[BUSW-1:OPW];
   assign b_w = opnd_i[OPW-1:0];

   qa_addsub #(.OPW(OPW), .RESW(RESW)) u_addsub (
      .a_i   (a_w),
      .b_i   (b_w),
      .sum_o (sum_o),
      .mag_o (diff_o),
      .neg_o (neg_o)
   );

   qa_mul #(.OPW(OPW), .RESW(RESW), .STYLE(MUL_STYLE)) u_mul (
      .a_i    (a_w),
      .b_i    (b_w),
      .prod_o (prod_o)
   );

   qa_div #(.OPW(OPW), .RESW(RESW)) u_div (
      .a_i    (a_w),
      .b_i    (b_w),
      .quot_o (quot_o),
      .zero_o (dz_o)
   );
endmodule

// File: rtl/quad_op_alu_chk.sv
module quad_op_alu_chk #(
   parameter int unsigned OPW  = 2,
   parameter int unsigned RESW = 4
) (
   input logic [2*OPW-1:0] opnd_i,
   input logic [RESW-1:0]  sum_o,
   input logic [RESW-1:0]  diff_o,
   input logic [RESW-1:0]  prod_o,
   input logic [RESW-1:0]  quot_o,
   input logic             neg_o,
   input logic             dz_o
);
   int unsigned av, bv, sv, dv, pv, qv;

   always_comb begin
      av = 32'(opnd_i[2*OPW-1:OPW]);
      bv = 32'(opnd_i[OPW-1:0]);
      sv = 32'(sum_o);
      dv = 32'(diff_o);
      pv = 32'(prod_o);
      qv = 32'(quot_o);
      // R2
      p_sum_exact_r2: assert (sv >= bv && sv - bv == av)
         else $error("sum mismatch");
      // R3
      p_diff_mag_r3: assert (neg_o ? (av + dv == bv && dv != 0) : (bv + dv == av))
         else $error("difference mismatch");
      // R4
      p_equal_pos_r4: assert (!(av == bv) || (!neg_o && dv == 0))
         else $error("equal operands not zero/positive");
      // R5
      p_no_overflow_r5: assert (pv <= av * bv && pv >= av * bv)
         else $error("product mismatch");
      // R6
      p_quot_bound_r6: assert (dz_o || (qv * bv <= av && av < (qv + 1) * bv))
         else $error("quotient out of bounds");
      // R7
      p_dz_flag_r7: assert (dz_o == (bv == 0))
         else $error("divide-by-zero flag mismatch");
      // R8
      p_dz_quot_r8: assert (!dz_o || qv == 0)
         else $error("quotient not zero on zero divisor");
   end
endmodule

bind quad_op_alu quad_op_alu_chk #(.OPW(OPW), .RESW(RESW)) u_chk (
   .opnd_i (opnd_i),
   .sum_o  (sum_o),
   .diff_o (diff_o),
   .prod_o (prod_o),
   .quot_o (quot_o),
   .neg_o  (neg_o),
   .dz_o   (dz_o)
);

// File: tb/quad_op_alu_test.sv
module quad_op_alu_test;
   localparam int CLK_PERIOD = 10;
   localparam int OPW        = 2;
   localparam int RESW       = 4;
   localparam int N_RAND     = 48;
   localparam int WDOG_LIMIT = 5000;

   logic            clk = 1'b0;
   logic [2*OPW-1:0] opnd = '0;
   logic [RESW-1:0]  sum_w, diff_w, prod_w, quot_w;
   logic             neg_w, dz_w;

   int total = 0;
   int bad   = 0;
   int cycles = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   quad_op_alu #(.OPW(OPW), .RESW(RESW)) uut (
      .opnd_i (opnd),
      .sum_o  (sum_w),
      .diff_o (diff_w),
      .prod_o (prod_w),
      .quot_o (quot_w),
      .neg_o  (neg_w),
      .dz_o   (dz_w)
   );

   function automatic int ref_sum(int a, int b);  return a + b; endfunction
   function automatic int ref_neg(int a, int b);  return (a < b) ? 1 : 0; endfunction
   function automatic int ref_diff(int a, int b); return (a < b) ? b - a : a - b; endfunction
   function automatic int ref_prod(int a, int b); return a * b; endfunction
   function automatic int ref_dz(int b);          return (b == 0) ? 1 : 0; endfunction
   function automatic int ref_quot(int a, int b); return (b == 0) ? 0 : a / b; endfunction

   task automatic chk(string req, int act, int exp, int a, int b);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
      end
   endtask

   // applies a pair after the rising edge, samples at the falling edge (R9: same cycle)
   task automatic apply_and_check(int a, int b);
      @(posedge clk);
      #1 opnd = {a[OPW-1:0], b[OPW-1:0]};
      @(negedge clk);
      chk("R2 sum",  int'(sum_w),  ref_sum(a, b),  a, b);
      chk("R5 prod", int'(prod_w), ref_prod(a, b), a, b);
      chk("R7 dz",   int'(dz_w),   ref_dz(b),      a, b);
      if (a == b) begin
         chk("R4 neg on equal",  int'(neg_w),  0, a, b);
         chk("R4 diff on equal", int'(diff_w), 0, a, b);
      end else begin
         chk("R3 neg",  int'(neg_w),  ref_neg(a, b),  a, b);
         chk("R3 diff", int'(diff_w), ref_diff(a, b), a, b);
      end
      if (b == 0) chk("R8 quot zero divisor", int'(quot_w), 0, a, b);
      else        chk("R6 quot",             int'(quot_w), ref_quot(a, b), a, b);
   endtask

   initial begin
      int unsigned seed_dummy;
      // reset state: bus at zero
      @(negedge clk);
      chk("R7 dz at start",   int'(dz_w),   1, 0, 0);
      chk("R8 quot at start", int'(quot_w), 0, 0, 0);
      chk("R2 sum at start",  int'(sum_w),  0, 0, 0);
      // R1: operand placement, upper pair is first operand: 3,1 -> diff 2 positive
      apply_and_check(3, 1);
      chk("R1 upper pair is first", int'(neg_w), 0, 3, 1);
      apply_and_check(1, 3);
      chk("R1 lower pair is second", int'(neg_w), 1, 1, 3);
      chk("R3 one minus three", int'(diff_w), 2, 1, 3);
      apply_and_check(3, 2);
      chk("R6 three over two", int'(quot_w), 1, 3, 2);
      apply_and_check(3, 3);
      chk("R5 max product", int'(prod_w), 9, 3, 3);
      chk("R2 max sum",     int'(sum_w),  6, 3, 3);
      apply_and_check(3, 0);
      chk("R8 three over zero", int'(quot_w), 0, 3, 0);
      // full directed sweep
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            apply_and_check(a, b);
      // seeded random pairs
      seed_dummy = $urandom(32'd1207);
      for (int n = 0; n < N_RAND; n++) begin
         int unsigned r;
         r = $urandom;
         apply_and_check(int'(r[3:2]), int'(r[1:0]));
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!done && cycles >= WDOG_LIMIT) begin
         total = total + 1;
         bad   = bad + 1;
         $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WDOG_LIMIT);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule